// File: doc/BRIEF.md
# Crate-Bus Command Decoder and Window Register File

This block is the command end of a crate-style backplane bus for a video sampling window controller. Each request carries a function code, a subaddress and write data. The block decodes the pair and then does one of three things. It reads one of six window parameters, it writes one of them, or it sends a one-cycle arm pulse to the trigger sequencer. The six parameters feed the sampling clock generator directly: start and stop of the pixel span, start and stop of the line span, and a decimation setting for each direction.

Requests enter on a valid/ready channel. Every accepted request produces exactly one response beat on a second valid/ready channel. The beat carries read data and a hit flag, which tells whether the function/subaddress pair was recognised.

Back-pressure rules:
- The request side is ready whenever no response is pending, or the pending response is being taken in the same cycle.
- A response that is not taken holds its value until `rsp_ready` is seen high.
- A write or an arm takes effect on the clock edge that accepts it, even if its response is stalled afterwards.

Top module: `crate_cmd_regs`

## Requirements
- R1: After reset, all six parameter outputs are zero, `rsp_valid` and `arm_pulse` are low, and `req_ready` is high.
- R2: An accepted write (function 16) at subaddress 0..5 loads the low bits of `req_wdata` into the addressed parameter. Subaddress 0 is pixel start and 1 is pixel stop, 9 bits each. Subaddress 2 is line start and 3 is line stop, 8 bits each. Subaddress 4 is pixel decimation and 5 is line decimation, 4 bits each. Write bits above the field width are ignored. The new value appears on the outputs in the cycle after acceptance.
- R3: An accepted read (function 0) at subaddress 0..5 returns the addressed parameter in the low bits of `rsp_rdata`, with all upper bits zero and `rsp_hit` high.
- R4: An accepted request with function 25 at subaddress 0 raises `arm_pulse` for exactly the cycle after acceptance and returns `rsp_hit` high. No other request raises `arm_pulse`.
- R5: Any other function/subaddress pair returns `rsp_hit` low and `rsp_rdata` zero. It changes no parameter and raises no arm pulse. Writes and arm commands also return `rsp_rdata` zero.
- R6: While `rsp_valid` is high and `rsp_ready` is low, the response stays valid with `rsp_hit` and `rsp_rdata` unchanged, and `req_ready` is low.
- R7: Every accepted request makes `rsp_valid` high in the next cycle. A response taken with `rsp_ready` high and no new request leaves `rsp_valid` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_func | input | 5 | Function code |
| req_addr | input | 4 | Subaddress |
| req_wdata | input | 24 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | Pair recognised |
| rsp_rdata | output | 24 | Read data, zero-extended |
| arm_pulse | output | 1 | One-cycle arm to trigger sequencer |
| px_start | output | 9 | Pixel window start |
| px_stop | output | 9 | Pixel window stop |
| ln_start | output | 8 | Line window start |
| ln_stop | output | 8 | Line window stop |
| px_decim | output | 4 | Pixel decimation setting |
| ln_decim | output | 4 | Line decimation setting |

## Verification
Everything the block produces is due exactly one cycle after the accepting edge:
- the response beat, its hit flag and its read data;
- a written parameter value;
- the arm pulse.

The bench therefore drives each request at a falling edge and lets one rising edge accept it. It then samples every result at the following falling edge. It updates its own parameter model at the accepting edge.

When the bench stalls a response, it samples again at each later falling edge and expects held values and `req_ready` low. It confirms that `rsp_valid` has dropped one falling edge after the response is finally taken.

// File: rtl/crate_regs_pkg.sv
package crate_regs_pkg;
  localparam int FUNC_W  = 5;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 24;
  localparam int PX_W    = 9;
  localparam int LN_W    = 8;
  localparam int DEC_W   = 4;
  localparam int NUM_FLD = 6;

  localparam logic [FUNC_W-1:0] FN_READ  = 5'd0;
  localparam logic [FUNC_W-1:0] FN_WRITE = 5'd16;
  localparam logic [FUNC_W-1:0] FN_ARM   = 5'd25;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_ARM   = 2'd3
  } op_e;
endpackage

// File: rtl/crate_cmd_decode.sv
module crate_cmd_decode
  import crate_regs_pkg::*;
#(
  parameter int F_W = FUNC_W,
  parameter int A_W = ADDR_W,
  parameter int N   = NUM_FLD
) (
  input  logic [F_W-1:0] func,
  input  logic [A_W-1:0] addr,
  output op_e            op,
  output logic [N-1:0]   sel
);
  logic in_map;

  assign in_map = (int'(addr) < N);

  always_comb begin
    op = OP_NONE;
    if (func == F_W'(FN_READ) && in_map)
      op = OP_READ;
    else if (func == F_W'(FN_WRITE) && in_map)
      op = OP_WRITE;
    else if (func == F_W'(FN_ARM) && addr == '0)
      op = OP_ARM;
  end

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign sel[i] = (int'(addr) == i);
  end
endmodule

// File: rtl/crate_field_reg.sv
module crate_field_reg #(
  parameter int W   = 8,
  parameter int D_W = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [D_W-1:0] wdata,
  output logic [W-1:0]   q,
  output logic [D_W-1:0] rd
);
  logic unused_hi;

  assign unused_hi = ^wdata[D_W-1:W];

  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= '0;
    else if (we)
      q <= wdata[W-1:0];
  end

  assign rd = {{(D_W-W){1'b0}}, q};
endmodule

// File: rtl/crate_rsp_stage.sv
module crate_rsp_stage #(
  parameter int D_W = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           hit_in,
  input  logic [D_W-1:0] rdata_in,
  input  logic           arm_in,
  input  logic           rsp_ready,
  output logic           can_accept,
  output logic           rsp_valid,
  output logic           rsp_hit,
  output logic [D_W-1:0] rsp_rdata,
  output logic           arm_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rdata <= '0;
      arm_pulse <= 1'b0;
    end else begin
      arm_pulse <= load && arm_in;
      if (load) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= hit_in;
        rsp_rdata <= rdata_in;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assign can_accept = !rsp_valid || rsp_ready;
endmodule

// File: rtl/crate_cmd_regs.sv
module crate_cmd_regs
  import crate_regs_pkg::*;
#(
  parameter int F_W = FUNC_W,
  parameter int A_W = ADDR_W,
  parameter int D_W = DATA_W,
  parameter int P_W = PX_W,
  parameter int L_W = LN_W,
  parameter int R_W = DEC_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [F_W-1:0] req_func,
  input  logic [A_W-1:0] req_addr,
  input  logic [D_W-1:0] req_wdata,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic           rsp_hit,
  output logic [D_W-1:0] rsp_rdata,
  output logic           arm_pulse,
  output logic [P_W-1:0] px_start,
  output logic [P_W-1:0] px_stop,
  output logic [L_W-1:0] ln_start,
  output logic [L_W-1:0] ln_stop,
  output logic [R_W-1:0] px_decim,
  output logic [R_W-1:0] ln_decim
);
  localparam int N = NUM_FLD;

  function automatic int fld_w(int idx);
    if (idx < 2)      return P_W;
    else if (idx < 4) return L_W;
    else              return R_W;
  endfunction

  op_e            op;
  logic [N-1:0]   sel;
  logic           accept;
  logic [N-1:0]   we;
  logic [D_W-1:0] rd_vec [N];
  logic [D_W-1:0] rd_mux;

  assign accept = req_valid && req_ready;

  crate_cmd_decode #(.F_W(F_W), .A_W(A_W), .N(N)) u_dec (
    .func (req_func),
    .addr (req_addr),
    .op   (op),
    .sel  (sel)
  );

  for (genvar i = 0; i < N; i++) begin : g_fld
    localparam int W = fld_w(i);
    logic [W-1:0] q_i;

    assign we[i] = accept && (op == OP_WRITE) && sel[i];

    crate_field_reg #(.W(W), .D_W(D_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we[i]),
      .wdata (req_wdata),
      .q     (q_i),
      .rd    (rd_vec[i])
    );

    if (i == 0) begin : g_o0
      assign px_start = q_i;
    end else if (i == 1) begin : g_o1
      assign px_stop = q_i;
    end else if (i == 2) begin : g_o2
      assign ln_start = q_i;
    end else if (i == 3) begin : g_o3
      assign ln_stop = q_i;
    end else if (i == 4) begin : g_o4
      assign px_decim = q_i;
    end else begin : g_o5
      assign ln_decim = q_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (op == OP_READ) begin
      for (int i = 0; i < N; i++) begin
        if (sel[i]) rd_mux = rd_mux | rd_vec[i];
      end
    end
  end

  crate_rsp_stage #(.D_W(D_W)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .hit_in     (op != OP_NONE),
    .rdata_in   (rd_mux),
    .arm_in     (op == OP_ARM),
    .rsp_ready  (rsp_ready),
    .can_accept (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_rdata  (rsp_rdata),
    .arm_pulse  (arm_pulse)
  );
endmodule

// File: rtl/crate_regs_chk.sv
module crate_regs_chk
  import crate_regs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [FUNC_W-1:0] req_func,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              arm_pulse,
  input logic [PX_W-1:0]   px_start,
  input logic [PX_W-1:0]   px_stop,
  input logic [LN_W-1:0]   ln_start,
  input logic [LN_W-1:0]   ln_stop,
  input logic [DEC_W-1:0]  px_decim,
  input logic [DEC_W-1:0]  ln_decim
);
  logic acc;
  assign acc = req_valid && req_ready;

  AST_WRITE_PX_START: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_func == FN_WRITE && req_addr == 4'd0) |=> px_start == $past(req_wdata[PX_W-1:0])); // R2

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && req_func == FN_WRITE) |=> $stable({px_start, px_stop, ln_start, ln_stop, px_decim, ln_decim})); // R5

  AST_READ_LN_START: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_func == FN_READ && req_addr == 4'd2) |=> rsp_hit && rsp_rdata == DATA_W'($past(ln_start))); // R3

  AST_ARM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    arm_pulse |-> $past(acc && req_func == FN_ARM && req_addr == 4'd0)); // R4

  AST_UNKNOWN_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_func != FN_READ && req_func != FN_WRITE && req_func != FN_ARM) |=> !rsp_hit && rsp_rdata == '0); // R5

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_rdata)); // R6

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R7
endmodule

bind crate_cmd_regs crate_regs_chk u_chk (.*);

// File: tb/crate_cmd_regs_test.sv
module crate_cmd_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_func = '0;
  logic [3:0]  req_addr = '0;
  logic [23:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [23:0] rsp_rdata;
  logic        arm_pulse;
  logic [8:0]  px_start, px_stop;
  logic [7:0]  ln_start, ln_stop;
  logic [3:0]  px_decim, ln_decim;

  int checks = 0;
  int errors = 0;
  logic [8:0] mdl [6];

  always #10 clk = ~clk;

  crate_cmd_regs uut (.*);

  function automatic logic [8:0] fmask(int a);
    return (a < 2) ? 9'h1FF : (a < 4) ? 9'h0FF : 9'h00F;
  endfunction

  function automatic bit exp_hit(logic [4:0] f, logic [3:0] a);
    return ((f == 5'd0 || f == 5'd16) && a < 4'd6) || (f == 5'd25 && a == 4'd0);
  endfunction

  function automatic logic [23:0] exp_rd(logic [4:0] f, logic [3:0] a);
    if (f == 5'd0 && a < 4'd6) return {15'd0, mdl[a]};
    return 24'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk(px_start == mdl[0], tag, 32'(px_start), 32'(mdl[0]));
    chk(px_stop  == mdl[1], tag, 32'(px_stop),  32'(mdl[1]));
    chk(ln_start == mdl[2][7:0], tag, 32'(ln_start), 32'(mdl[2]));
    chk(ln_stop  == mdl[3][7:0], tag, 32'(ln_stop),  32'(mdl[3]));
    chk(px_decim == mdl[4][3:0], tag, 32'(px_decim), 32'(mdl[4]));
    chk(ln_decim == mdl[5][3:0], tag, 32'(ln_decim), 32'(mdl[5]));
  endtask

  task automatic issue(input logic [4:0] f, input logic [3:0] a, input logic [23:0] d, input int stall);
    bit h;
    bit arm;
    logic [23:0] r;
    string tag;
    h   = exp_hit(f, a);
    r   = exp_rd(f, a);
    arm = (f == 5'd25 && a == 4'd0);
    tag = !h ? "R5" : (f == 5'd16) ? "R2" : (f == 5'd0) ? "R3" : "R4";
    @(negedge clk);
    req_valid = 1'b1; req_func = f; req_addr = a; req_wdata = d; rsp_ready = 1'b1;
    chk(req_ready == 1'b1, "R6", 32'(req_ready), 32'd1);
    @(posedge clk);
    if (f == 5'd16 && a < 4'd6) mdl[a] = d[8:0] & fmask(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R7", 32'(rsp_valid), 32'd1);
    chk(rsp_hit == h, tag, 32'(rsp_hit), 32'(h));
    chk(rsp_rdata == r, tag, 32'(rsp_rdata), 32'(r));
    chk(arm_pulse == arm, "R4", 32'(arm_pulse), 32'(arm));
    chk_regs(tag);
    if (stall > 0) rsp_ready = 1'b0;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b1 && rsp_hit == h, "R6", 32'(rsp_valid), 32'd1);
      chk(rsp_rdata == r, "R6", 32'(rsp_rdata), 32'(r));
      chk(req_ready == 1'b0, "R6", 32'(req_ready), 32'd0);
      chk(arm_pulse == 1'b0, "R4", 32'(arm_pulse), 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7", 32'(rsp_valid), 32'd0);
    chk(arm_pulse == 1'b0, "R4", 32'(arm_pulse), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd20917);
    for (int i = 0; i < 6; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 1'b0 && arm_pulse == 1'b0, "R1", 32'({rsp_valid, arm_pulse}), 32'd0);
    chk_regs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", 32'(req_ready), 32'd1);

    // R2: all-ones writes, upper bits dropped; R3 read back
    for (int a = 0; a < 6; a++) issue(5'd16, 4'(a), 24'hFFFFFF, 0);
    for (int a = 0; a < 6; a++) issue(5'd0, 4'(a), 24'h0, 0);
    issue(5'd16, 4'd3, 24'h123A5, 0);
    issue(5'd0, 4'd3, 24'h0, 2);
    // R4: arm command, with and without stall
    issue(5'd25, 4'd0, 24'h0, 0);
    issue(5'd25, 4'd0, 24'hABCDEF, 3);
    // R5: unmapped pairs leave state alone
    issue(5'd0, 4'd6, 24'h0, 0);
    issue(5'd16, 4'd7, 24'h1FF, 0);
    issue(5'd16, 4'd15, 24'hFFFFFF, 1);
    issue(5'd25, 4'd1, 24'h0, 0);
    issue(5'd8, 4'd0, 24'h55, 0);
    issue(5'd24, 4'd2, 24'hFF, 0);

    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      logic [4:0] f;
      int sel;
      sel = int'($urandom_range(0, 3));
      f = (sel == 0) ? 5'd0 : (sel == 1) ? 5'd16 : (sel == 2) ? 5'd25 : 5'($urandom());
      issue(f, 4'($urandom_range(0, 7)), 24'($urandom()), int'($urandom_range(0, 2)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule